// File: doc/BRIEF.md
# Reference Pulse Divider with Snapshot Strobe

This block divides an external reference pulse train (nominally 128 kHz) by a ratio the host programs. Each time the programmed number of reference rising edges has been counted, the period counter clears and two things happen at once: a one-cycle sample strobe goes out to the measurement counters so that they all latch together, and a host interrupt level is raised. A 16-bit status word, one bit per external status line (driving state, high-voltage, vibration and mode-detect lines), is captured in a held register on the same edge.

The host writes the division value into a preset register. The period in progress always finishes under the ratio it started with. The interrupt stays asserted until the host clears it. The reference input is asynchronous and passes through a two-flop synchroniser before its rising edges are counted.

Top module: `ref_divider_snap`

## Requirements
- R1: After reset, irq_o and strobe_o are 0, status_snap_o is 0 and the division value is DIV_INIT (default 4).
- R2: ref_i passes through two synchronising flops. Only its rising edges are counted, and a high level of any length counts as one pulse.
- R3: With division value N (N >= 2), strobe_o pulses once for every N counted rising edges. The period count then clears and the next period starts.
- R4: A division value of 0 or of 1 gives one strobe for every rising edge of ref_i.
- R5: A pulse on div_we_i loads div_data_i into the preset. A write during a period that has already counted an edge takes effect from the next period. A write made when no edge of the current period has yet been counted governs that period.
- R6: strobe_o is high for exactly one clock cycle. It rises on the third rising clock edge after ref_i goes high, counting the edge on which ref_i is first sampled.
- R7: irq_o rises on the same edge as strobe_o and stays high until a cycle with irq_clr_i high. When a set and a clear fall in the same cycle, the set wins.
- R8: status_snap_o loads status_i on the clock edge on which strobe_o rises and holds that value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Asynchronous reference pulse train |
| div_we_i | input | 1 | Host write strobe for the division value |
| div_data_i | input | DIV_W | Division value to write |
| irq_clr_i | input | 1 | Host interrupt clear |
| status_i | input | STAT_W | Live status lines, one bit each |
| irq_o | output | 1 | Interrupt level to the host |
| strobe_o | output | 1 | One-cycle sample strobe to the counter bank |
| status_snap_o | output | STAT_W | Status word held from the last strobe |

## Verification
If the period count is off, strobes show up one or more reference pulses early or late. The error appears at the first terminal count, within one period of the fault. If the preset is applied at the wrong time, the period that straddles a mid-period write comes out with the wrong length, so that period and the one after it are both checked. Faults in the synchroniser or edge detector show up as a shifted strobe cycle or as extra counts on long high pulses. Faults in the interrupt or snapshot registers show up in the cycle each strobe is sampled, as a wrong level or a stale status word.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int unsigned DIV_W_DEF  = 16;
  localparam int unsigned STAT_W_DEF = 16;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/ref_edge_det.sv
module ref_edge_det #(
  parameter int unsigned STAGES = ref_div_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES;

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], ref_i};
  end

  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];

  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ref_div_counter.sv
module ref_div_counter #(
  parameter int unsigned DIV_W    = ref_div_pkg::DIV_W_DEF,
  parameter int unsigned DIV_INIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             we_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic             hit_o,
  output logic             strobe_o
);
  localparam int unsigned CW = DIV_W + 1;
  localparam logic [DIV_W-1:0] INIT_V = DIV_W'(DIV_INIT);

  logic [DIV_W-1:0] preset_q, lim_q, cnt_q;
  logic [DIV_W-1:0] lim_now, lim_eff;
  logic             strobe_q;

  // a period latches its limit on its first counted edge
  assign lim_now = (cnt_q == '0) ? preset_q : lim_q;
  assign lim_eff = (lim_now == '0) ? DIV_W'(1) : lim_now;
  assign hit_o   = rise_i && ((CW'(cnt_q) + CW'(1)) >= CW'(lim_eff));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_q <= INIT_V;
      lim_q    <= INIT_V;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (we_i) preset_q <= wdata_i;
      if (rise_i) begin
        if (cnt_q == '0) lim_q <= preset_q;
        cnt_q <= hit_o ? '0 : cnt_q + DIV_W'(1);
      end
      strobe_q <= hit_o;
    end
  end

  assign strobe_o = strobe_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q < lim_q));
  p_cnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(cnt_q));
  p_strobe_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/ref_irq_ctrl.sv
module ref_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_o);
  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  p_irq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/ref_divider_snap.sv
module ref_divider_snap #(
  parameter int unsigned DIV_W    = ref_div_pkg::DIV_W_DEF,
  parameter int unsigned STAT_W   = ref_div_pkg::STAT_W_DEF,
  parameter int unsigned SYNC     = ref_div_pkg::SYNC_DEF,
  parameter int unsigned DIV_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_data_i,
  input  logic              irq_clr_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              irq_o,
  output logic              strobe_o,
  output logic [STAT_W-1:0] status_snap_o
);
  logic rise, hit;
  logic [STAT_W-1:0] snap_q;

  ref_edge_det #(.STAGES(SYNC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .rise_o(rise)
  );

  ref_div_counter #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .we_i    (div_we_i),
    .wdata_i (div_data_i),
    .hit_o   (hit),
    .strobe_o(strobe_o)
  );

  ref_irq_ctrl u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  snap_q <= '0;
    else if (hit) snap_q <= status_i;
  end

  assign status_snap_o = snap_q;

  p_snap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(snap_q));
  p_strobe_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (strobe_o && irq_o));
endmodule

// File: tb/ref_divider_snap_tb_top.sv
module ref_divider_snap_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_i = 1'b0;
  logic        div_we_i = 1'b0;
  logic [15:0] div_data_i = '0;
  logic        irq_clr_i = 1'b0;
  logic [15:0] status_i = '0;
  logic        irq_o, strobe_o;
  logic [15:0] status_snap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  logic prev_strobe = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ref_divider_snap dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .div_we_i(div_we_i),
    .div_data_i(div_data_i), .irq_clr_i(irq_clr_i), .status_i(status_i),
    .irq_o(irq_o), .strobe_o(strobe_o), .status_snap_o(status_snap_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: every strobe consumes one scoreboard entry
  always @(negedge clk_i) begin
    if (rst_ni && strobe_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", 32'(strobe_o), 32'd0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(status_snap_o == e, "R8 snapshot", 32'(status_snap_o), 32'(e));
        chk(irq_o == 1'b1, "R7 irq with strobe", 32'(irq_o), 32'd1);
      end
      chk(!prev_strobe, "R6 strobe width", 32'(prev_strobe), 32'd0);
    end
    prev_strobe = strobe_o;
  end

  task automatic write_div(input logic [15:0] v);
    @(negedge clk_i); div_we_i = 1'b1; div_data_i = v;
    @(negedge clk_i); div_we_i = 1'b0;
  endtask

  task automatic ref_pulse(input bit tc, input bit clr_at_tc, input int hi);
    @(negedge clk_i); ref_i = 1'b1;
    if (tc) exp_q.push_back(status_i);
    @(negedge clk_i);
    @(negedge clk_i); if (clr_at_tc) irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
    chk(strobe_o == tc, "R6 strobe latency/R3 period", 32'(strobe_o), 32'(tc));
    @(negedge clk_i);
    chk(strobe_o == 1'b0, "R6 one cycle", 32'(strobe_o), 32'd0);
    repeat (hi - 4) @(negedge clk_i);
    ref_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic clear_irq();
    @(negedge clk_i); irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
    chk(irq_o == 1'b0, "R7 clear", 32'(irq_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    chk(irq_o == 0 && strobe_o == 0, "R1 reset outputs", {30'd0, irq_o, strobe_o}, 32'd0);
    chk(status_snap_o == 0, "R1 reset snapshot", 32'(status_snap_o), 32'd0);
    rst_ni = 1'b1;
    status_i = 16'hA5C3;
    // R1: default ratio 4
    for (int i = 0; i < 3; i++) ref_pulse(1'b0, 1'b0, 4);
    ref_pulse(1'b1, 1'b0, 4);
    // R2: long high level counts once
    write_div(16'd2);
    status_i = 16'h1234;
    ref_pulse(1'b0, 1'b0, 20);
    ref_pulse(1'b1, 1'b0, 4);
    // R7: level holds while idle, then clears
    repeat (10) @(negedge clk_i);
    chk(irq_o == 1'b1, "R7 level held", 32'(irq_o), 32'd1);
    clear_irq();
    // R5: mid-period write applies from next period
    ref_pulse(1'b0, 1'b0, 4);
    write_div(16'd5);
    status_i = 16'h0F0F;
    ref_pulse(1'b1, 1'b0, 4);
    for (int i = 0; i < 4; i++) ref_pulse(1'b0, 1'b0, 4);
    status_i = 16'hBEEF;
    ref_pulse(1'b1, 1'b0, 5);
    // R4: ratio 0 and 1
    write_div(16'd0);
    for (int i = 0; i < 3; i++) begin
      status_i = 16'(16'h0100 << i);
      ref_pulse(1'b1, 1'b0, 4);
    end
    write_div(16'd1);
    status_i = 16'h8001;
    ref_pulse(1'b1, 1'b0, 4);
    // R8: snapshot holds when status changes without a strobe
    status_i = 16'h7777;
    repeat (6) @(negedge clk_i);
    chk(status_snap_o == 16'h8001, "R8 hold", 32'(status_snap_o), 32'h8001);
    // R7: set wins over a simultaneous clear
    clear_irq();
    status_i = 16'h4242;
    ref_pulse(1'b1, 1'b1, 4);
    repeat (3) @(negedge clk_i);
    chk(irq_o == 1'b1, "R7 set wins", 32'(irq_o), 32'd1);
    clear_irq();
    chk(exp_q.size() == 0, "R3 missing strobes", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule